// File: doc/BRIEF.md
# Reconfigurable Systolic MAC Array

This block is a square grid of multiply-accumulate cells that multiplies small integer matrices in either of two dataflows, chosen at run time. In the weight-held flow every cell first receives a weight, which is shifted down its column during a load phase and then kept. Activation vectors then enter from the left edge and move one cell right per cycle. Running sums enter at the top and move one cell down per cycle, so every column emits one dot product per vector at the bottom edge.

In the output-held flow, activations still move right, weights now move down, and every cell adds the product of the two operands that meet there into its own 16-bit signed accumulator. A cell skips the update when either operand is zero, and its accumulator then keeps its value. A clear input zeroes every accumulator. A drain input shifts the accumulators down their columns and out of the bottom edge, one row per cycle. Both flows accept either one signed 4-bit multiply per cell per cycle, or two packed signed 2-bit multiplies whose products are added together.

The caller applies the input skew: row r of the activations and column c of the weights and top sums are presented r or c cycles late. Flow and precision are changed only while nothing is in flight.

Top module: `sa_array`

## Requirements
- R1: While reset is held and after it is released, with no activity, every out_valid bit is 0 and every out_data lane is 0.
- R2: With mode_os=0 and wload=1, each cycle shifts wgt_in lane c into the top cell of column c and moves held weights one row down. After ROWS load cycles the value presented first sits in the bottom row. With wload=0 the weights do not change.
- R3: With mode_os=0, a vector whose row-r element is presented on act_in lane r with in_valid[r]=1, r cycles after its row-0 element, appears on out_data lane c ROWS+c cycles after its row-0 element, with out_valid[c]=1. The value is psum_in lane c (presented c cycles after row 0) plus the sum over r of act(r) times weight(r,c).
- R4: With mode_os=1, if A(r,k) is presented on act_in lane r at cycle k+r with in_valid[r]=1 and B(k,c) on wgt_in lane c at cycle k+c, cell (r,c) accumulates the sum over k of A(r,k)*B(k,c).
- R5: With prec_half=0, each 4-bit operand is a two's complement value from -8 to 7. The product of -8 and -8 is 64.
- R6: With prec_half=1, bits [1:0] and [3:2] of each operand are independent two's complement 2-bit values. The product is lo(a)*lo(w)+hi(a)*hi(w), in both flows.
- R7: With mode_os=1, a cell whose arriving activation or weight is zero leaves its accumulator unchanged in that cycle.
- R8: A one-cycle clr pulse sets every accumulator to zero. A later tile then accumulates from zero.
- R9: A one-cycle drain pulse with mode_os=1 gives exactly ROWS consecutive cycles with every out_valid bit set. Lane c shows the accumulator of row ROWS-1 first and of row 0 last. Afterwards all accumulators are zero.
- R10: mode_os and prec_half change only in a cycle that follows one with no in_valid bit set and no drain in progress.
- R11: With mode_os=0, out_valid[c] is set only for vectors that were presented with in_valid set. Gaps in the input stream produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_os | input | 1 | 0: weight-held flow, 1: output-held flow |
| prec_half | input | 1 | 0: one 4-bit product, 1: two packed 2-bit products |
| wload | input | 1 | Weight load shift enable (weight-held flow) |
| clr | input | 1 | Zero all accumulators |
| drain | input | 1 | Start shifting accumulators out (output-held flow) |
| in_valid | input | ROWS | Per-row activation valid, skewed like act_in |
| act_in | input | ROWS*DW | Row activation lanes, lane r at bits [r*DW +: DW] |
| wgt_in | input | COLS*DW | Column weight lanes, lane c at bits [c*DW +: DW] |
| psum_in | input | COLS*AW | Top-edge running sums for the weight-held flow |
| out_valid | output | COLS | Per-column result valid |
| out_data | output | COLS*AW | Bottom-edge results, lane c at bits [c*AW +: AW] |

## Verification
The bench builds the array with its defaults, 4 rows by 4 columns, 4-bit operands and 16-bit sums. At this size the full skew, the drain order and the four-cycle load phase stay short enough to hit many times in one run. Each column's output is matched against a queue of reference products. The stimulus covers both flows and both precisions, operand extremes such as -8 times -8, matrices that are mostly zeros, gaps in the activation stream, and a clear between two tiles followed by an empty drain.

// File: rtl/sa_pkg.sv
package sa_pkg;
  typedef enum logic {
    FLOW_WS = 1'b0,
    FLOW_OS = 1'b1
  } flow_e;

  typedef enum logic {
    PREC_FULL = 1'b0,
    PREC_HALF = 1'b1
  } prec_e;

  localparam int unsigned DEF_ROWS = 4;
  localparam int unsigned DEF_COLS = 4;
  localparam int unsigned DEF_DW   = 4;
  localparam int unsigned DEF_AW   = 16;
endpackage

// File: rtl/sa_mac.sv
module sa_mac #(
  parameter int unsigned DW = 4,
  parameter int unsigned PW = 16
) (
  input  logic          half,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] w,
  output logic [PW-1:0] prod
);
  localparam int unsigned HW = DW / 2;
  localparam int unsigned FW = 2 * DW;
  localparam int unsigned LW = 2 * HW;

  logic signed [FW-1:0] full_p;
  logic signed [LW-1:0] lo_p;
  logic signed [LW-1:0] hi_p;
  logic signed [LW:0]   pair_p;

  always_comb begin
    full_p = $signed(a) * $signed(w);
    lo_p   = $signed(a[HW-1:0]) * $signed(w[HW-1:0]);
    hi_p   = $signed(a[DW-1:HW]) * $signed(w[DW-1:HW]);
    pair_p = lo_p + hi_p;
    if (half) prod = {{(PW-LW-1){pair_p[LW]}}, pair_p};
    else      prod = {{(PW-FW){full_p[FW-1]}}, full_p};
  end
endmodule

// File: rtl/sa_pe.sv
module sa_pe #(
  parameter int unsigned DW = 4,
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_mode,
  input  logic          half,
  input  logic          wload,
  input  logic          clr,
  input  logic          shift,
  input  logic [DW-1:0] a_in,
  input  logic          v_in,
  input  logic [DW-1:0] w_in,
  input  logic [AW-1:0] psum_in,
  input  logic [AW-1:0] acc_in,
  output logic [DW-1:0] a_out,
  output logic          v_out,
  output logic [DW-1:0] w_out,
  output logic [AW-1:0] psum_out,
  output logic [AW-1:0] acc_out
);
  logic [DW-1:0] a_q, w_q, w_op;
  logic          v_q;
  logic [AW-1:0] psum_q, psum_d;
  logic [AW-1:0] acc_q, acc_d;
  logic [AW-1:0] prod;
  logic          w_en, psum_en, acc_en, mac_en, skip;

  sa_mac #(.DW(DW), .PW(AW)) u_mac (
    .half (half),
    .a    (a_in),
    .w    (w_op),
    .prod (prod)
  );

  always_comb begin
    w_op    = os_mode ? w_in : w_q;
    w_en    = os_mode | wload;
    skip    = (a_in == '0) | (w_in == '0);
    mac_en  = os_mode & v_in & ~skip;
    acc_en  = clr | shift | mac_en;
    psum_en = ~os_mode;
    psum_d  = psum_in + (v_in ? prod : '0);
    if (clr)        acc_d = '0;
    else if (shift) acc_d = acc_in;
    else            acc_d = acc_q + prod;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      v_q    <= 1'b0;
      w_q    <= '0;
      psum_q <= '0;
      acc_q  <= '0;
    end else begin
      a_q <= a_in;
      v_q <= v_in;
      if (w_en)    w_q    <= w_in;
      if (psum_en) psum_q <= psum_d;
      if (acc_en)  acc_q  <= acc_d;
    end
  end

  assign a_out    = a_q;
  assign v_out    = v_q;
  assign w_out    = w_q;
  assign psum_out = psum_q;
  assign acc_out  = acc_q;

  p_skip_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (os_mode && !clr && !shift && ((a_in == '0) || (w_in == '0))) |=> $stable(acc_q));

  p_weight_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!os_mode && !wload) |=> $stable(w_q));

  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0));
endmodule

// File: rtl/sa_drain_ctrl.sv
module sa_drain_ctrl #(
  parameter int unsigned ROWS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic os_mode,
  input  logic drain,
  output logic busy
);
  localparam int unsigned CW = $clog2(ROWS + 1);
  localparam logic [CW-1:0] LAST = CW'(ROWS - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end
    end else if (drain && os_mode) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;

  p_cnt_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= LAST));

  p_drain_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/sa_array.sv
module sa_array
  import sa_pkg::*;
#(
  parameter int unsigned ROWS = DEF_ROWS,
  parameter int unsigned COLS = DEF_COLS,
  parameter int unsigned DW   = DEF_DW,
  parameter int unsigned AW   = DEF_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_os,
  input  logic               prec_half,
  input  logic               wload,
  input  logic               clr,
  input  logic               drain,
  input  logic [ROWS-1:0]    in_valid,
  input  logic [ROWS*DW-1:0] act_in,
  input  logic [COLS*DW-1:0] wgt_in,
  input  logic [COLS*AW-1:0] psum_in,
  output logic [COLS-1:0]    out_valid,
  output logic [COLS*AW-1:0] out_data
);
  logic  rst_meta, srst_n;
  flow_e flow;
  prec_e prec;
  logic  os, half, busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      srst_n   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      srst_n   <= rst_meta;
    end
  end

  assign flow = flow_e'(mode_os);
  assign prec = prec_e'(prec_half);
  assign os   = (flow == FLOW_OS);
  assign half = (prec == PREC_HALF);

  logic [DW-1:0] a_w  [ROWS][COLS+1];
  logic          v_w  [ROWS][COLS+1];
  logic [DW-1:0] w_w  [ROWS+1][COLS];
  logic [AW-1:0] ps_w [ROWS+1][COLS];
  logic [AW-1:0] ac_w [ROWS+1][COLS];

  sa_drain_ctrl #(.ROWS(ROWS)) u_drain (
    .clk     (clk),
    .rst_n   (srst_n),
    .os_mode (os),
    .drain   (drain),
    .busy    (busy)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row_edge
    assign a_w[r][0] = act_in[r*DW +: DW];
    assign v_w[r][0] = in_valid[r];
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col_edge
    assign w_w[0][c]  = wgt_in[c*DW +: DW];
    assign ps_w[0][c] = psum_in[c*AW +: AW];
    assign ac_w[0][c] = '0;
    assign out_data[c*AW +: AW] = os ? ac_w[ROWS][c] : ps_w[ROWS][c];
    assign out_valid[c]         = os ? busy : v_w[ROWS-1][c+1];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_r
    for (genvar c = 0; c < COLS; c++) begin : g_c
      sa_pe #(.DW(DW), .AW(AW)) u_pe (
        .clk      (clk),
        .rst_n    (srst_n),
        .os_mode  (os),
        .half     (half),
        .wload    (wload),
        .clr      (clr),
        .shift    (busy),
        .a_in     (a_w[r][c]),
        .v_in     (v_w[r][c]),
        .w_in     (w_w[r][c]),
        .psum_in  (ps_w[r][c]),
        .acc_in   (ac_w[r][c]),
        .a_out    (a_w[r][c+1]),
        .v_out    (v_w[r][c+1]),
        .w_out    (w_w[r+1][c]),
        .psum_out (ps_w[r+1][c]),
        .acc_out  (ac_w[r+1][c])
      );
    end
  end

  p_mode_idle_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (!$stable(mode_os) || !$stable(prec_half)) |-> ($past(in_valid) == '0 && !$past(busy)));

  p_load_flow_r2: assert property (@(posedge clk) disable iff (!srst_n)
    wload |-> !mode_os);
endmodule

// File: tb/sa_array_tb.sv
module sa_array_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int DW = 4;
  localparam int AW = 16;

  logic               clk, rst_n;
  logic               mode_os, prec_half, wload, clr, drain;
  logic [ROWS-1:0]    in_valid;
  logic [ROWS*DW-1:0] act_in;
  logic [COLS*DW-1:0] wgt_in;
  logic [COLS*AW-1:0] psum_in;
  logic [COLS-1:0]    out_valid;
  logic [COLS*AW-1:0] out_data;

  sa_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_os(mode_os), .prec_half(prec_half),
    .wload(wload), .clr(clr), .drain(drain), .in_valid(in_valid),
    .act_in(act_in), .wgt_in(wgt_in), .psum_in(psum_in),
    .out_valid(out_valid), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int    nvec = 0;
  int    nerr = 0;
  bit    mon_en = 0;
  bit    done = 0;
  int    exp_q [COLS][$];
  string tag_q [COLS][$];
  int    W [0:ROWS-1][0:COLS-1];
  int    Ma [0:15][0:3];
  int    Mb [0:15][0:3];
  int    Pp [0:15][0:3];
  bit    vv [0:15];

  function automatic int sx4(int x); return (x >= 8) ? x - 16 : x; endfunction
  function automatic int sx2(int x); return (x >= 2) ? x - 4 : x; endfunction
  function automatic int wrap16(int x);
    logic [15:0] t;
    t = x[15:0];
    return int'($signed(t));
  endfunction
  function automatic int bprod(int a, int w);
    if (prec_half) return sx2(a & 3) * sx2(w & 3) + sx2((a >> 2) & 3) * sx2((w >> 2) & 3);
    return sx4(a) * sx4(w);
  endfunction
  function automatic int gen(int zpct, int kind);
    if ($urandom_range(0, 99) < zpct) return 0;
    if (kind == 1) return ($urandom_range(0, 1) == 1) ? 8 : 7;
    return $urandom_range(0, 15);
  endfunction

  task automatic push(int c, int v, string tag);
    exp_q[c].push_back(wrap16(v));
    tag_q[c].push_back(tag);
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      for (int c = 0; c < COLS; c++) begin
        if (out_valid[c]) begin
          int got;
          got = int'($signed(out_data[c*AW +: AW]));
          nvec++;
          if (exp_q[c].size() == 0) begin
            nerr++;
            $display("FAIL R11 col %0d: unexpected output %0d, expected none", c, got);
          end else begin
            int e;
            string t;
            e = exp_q[c].pop_front();
            t = tag_q[c].pop_front();
            if (got != e) begin
              nerr++;
              $display("FAIL %s col %0d: got %0d expected %0d", t, c, got, e);
            end
          end
        end
      end
    end
  end

  task automatic zero_inputs();
    wload = 0; clr = 0; drain = 0; in_valid = '0;
    act_in = '0; wgt_in = '0; psum_in = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      zero_inputs();
    end
  endtask

  task automatic load_weights(int zpct);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) W[r][c] = gen(zpct, 0);
    for (int k = 0; k < ROWS; k++) begin
      @(negedge clk);
      zero_inputs();
      wload = 1;
      for (int c = 0; c < COLS; c++) wgt_in[c*DW +: DW] = 4'(W[ROWS-1-k][c]);
    end
    idle(1);
  endtask

  // onehot=1 puts a single 1 in row t of vector t to read back the held weights
  task automatic ws_stream(int T, int zpct, int kind, bit gaps, bit onehot, string tag);
    for (int t = 0; t < T; t++) begin
      vv[t] = gaps ? ($urandom_range(0, 2) != 0) : 1'b1;
      for (int r = 0; r < ROWS; r++) Ma[t][r] = onehot ? ((r == t % ROWS) ? 1 : 0) : gen(zpct, kind);
      for (int c = 0; c < COLS; c++) Pp[t][c] = onehot ? 0 : $urandom_range(0, 400) - 200;
    end
    for (int k = 0; k < T + ROWS + COLS; k++) begin
      @(negedge clk);
      zero_inputs();
      for (int r = 0; r < ROWS; r++) begin
        int t;
        t = k - r;
        if (t >= 0 && t < T && vv[t]) begin
          in_valid[r] = 1'b1;
          act_in[r*DW +: DW] = 4'(Ma[t][r]);
        end
      end
      for (int c = 0; c < COLS; c++) begin
        int t;
        t = k - c;
        if (t >= 0 && t < T) psum_in[c*AW +: AW] = 16'(Pp[t][c]);
      end
      if (k < T && vv[k]) begin
        for (int c = 0; c < COLS; c++) begin
          int s;
          s = Pp[k][c];
          for (int r = 0; r < ROWS; r++) s += bprod(Ma[k][r], W[r][c]);
          push(c, s, tag);
        end
      end
    end
    idle(2);
  endtask

  task automatic os_tile(int K, int zpct, int kind, bit do_drain, string tag);
    for (int k = 0; k < K; k++) begin
      for (int r = 0; r < ROWS; r++) Ma[k][r] = gen(zpct, kind);
      for (int c = 0; c < COLS; c++) Mb[k][c] = gen(zpct, kind);
    end
    for (int s = 0; s < K + ROWS + COLS; s++) begin
      @(negedge clk);
      zero_inputs();
      for (int r = 0; r < ROWS; r++) begin
        int k;
        k = s - r;
        if (k >= 0 && k < K) begin
          in_valid[r] = 1'b1;
          act_in[r*DW +: DW] = 4'(Ma[k][r]);
        end
      end
      for (int c = 0; c < COLS; c++) begin
        int k;
        k = s - c;
        if (k >= 0 && k < K) wgt_in[c*DW +: DW] = 4'(Mb[k][c]);
      end
    end
    idle(1);
    if (do_drain) begin
      @(negedge clk);
      zero_inputs();
      for (int j = 0; j < ROWS; j++)
        for (int c = 0; c < COLS; c++) begin
          int s;
          s = 0;
          for (int k = 0; k < K; k++) s += bprod(Ma[k][ROWS-1-j], Mb[k][c]);
          push(c, s, tag);
        end
      drain = 1;
      idle(ROWS + 2);
    end
  endtask

  task automatic empty_drain(string tag);
    @(negedge clk);
    zero_inputs();
    for (int j = 0; j < ROWS; j++)
      for (int c = 0; c < COLS; c++) push(c, 0, tag);
    drain = 1;
    idle(ROWS + 2);
  endtask

  task automatic set_mode(bit os, bit hp);
    @(negedge clk);
    zero_inputs();
    mode_os = os;
    prec_half = hp;
    idle(2);
  endtask

  initial begin
    int unsigned cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 0; mode_os = 0; prec_half = 0;
    zero_inputs();
    repeat (4) @(negedge clk);
    rst_n = 1;
    idle(4);
    // R1: quiet outputs after reset
    nvec++;
    if (out_valid !== '0 || out_data !== '0) begin
      nerr++;
      $display("FAIL R1: got valid %0h data %0h expected 0 0", out_valid, out_data);
    end
    mon_en = 1;

    load_weights(0);
    ws_stream(ROWS, 0, 0, 0, 1, "R2");
    ws_stream(8, 0, 0, 0, 0, "R3");
    ws_stream(8, 50, 0, 0, 0, "R3");
    load_weights(0);
    ws_stream(10, 0, 0, 1, 0, "R11");
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk);
      zero_inputs();
      wload = 1;
      for (int c = 0; c < COLS; c++) wgt_in[c*DW +: DW] = 4'h8;
    end
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) W[r][c] = 8;
    idle(1);
    ws_stream(6, 0, 1, 0, 0, "R5");
    set_mode(0, 1);
    load_weights(0);
    ws_stream(8, 20, 0, 0, 0, "R6");

    set_mode(1, 0);
    @(negedge clk); clr = 1;
    idle(1);
    os_tile(5, 0, 0, 1, "R4");
    os_tile(7, 0, 1, 1, "R5");
    os_tile(8, 70, 0, 1, "R7");
    os_tile(6, 0, 0, 0, "R8");
    @(negedge clk); zero_inputs(); clr = 1;
    idle(1);
    os_tile(6, 30, 0, 1, "R8");
    empty_drain("R9");
    set_mode(1, 1);
    os_tile(6, 40, 0, 1, "R6");
    os_tile(5, 0, 0, 1, "R9");

    idle(10);
    for (int c = 0; c < COLS; c++) begin
      while (exp_q[c].size() > 0) begin
        int e;
        string t;
        e = exp_q[c].pop_front();
        t = tag_q[c].pop_front();
        nvec++;
        nerr++;
        $display("FAIL %s col %0d: got no output expected %0d", t, c, e);
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule